// File: doc/BRIEF.md
# Three-Wire Addressed Register Loader

This block is a serial configuration port. It fills one of four 24-bit control registers from three slow pins: a serial clock, a serial data line and a load strobe. Bits shift in most significant first. When the load strobe rises, the two lowest bits of the shifted word select the destination register, and the whole word, with its index bits included, is copied there. The remaining registers keep their contents.

The three pins come from outside the chip and arrive with no timing relation to the system clock. Each one passes through a two-flop synchronizer, and edges are detected in the system clock domain. Every register update is synchronous to that clock.

A chip-enable input clears the shift register and all four registers while it is low, and it blocks loads during that time. Each time a register is written, a one-cycle strobe and the 2-bit index of the written register are presented, so that downstream logic can pick up the new setting.

Top module: `cfg_serial_loader`

## Requirements
- R1: While rst_ni is low, regs_o is all zero, wr_stb_o is 0 and wr_idx_o is 0.
- R2: A word holds 24 bits. The first bit shifted in becomes bit 23 and the last becomes bit 0, so a word of 24 bits is complete after 24 serial clock rises.
- R3: Serial data is captured only on a rising edge of the serial clock. A change of data while the serial clock is high, or at its falling edge, does not alter the word.
- R4: Bits [1:0] of the shifted word, value i, select the destination. A load copies the full 24-bit word to regs_o[24*i +: 24].
- R5: The three registers that are not addressed keep their values. A register changes only in a cycle where wr_stb_o reports it, or when chip-enable is low.
- R6: One rising edge of the load strobe produces exactly one write, however long the strobe stays high.
- R7: Each write produces wr_stb_o high for exactly one cycle, with wr_idx_o equal to the index of the register written in that cycle.
- R8: Serial clock rises that occur while the synchronized load strobe is high are ignored. The shift register keeps the word being transferred.
- R9: While ce_i is low, the shift register and all four registers are held at zero, and load strobes produce no write and no wr_stb_o.
- R10: Each pin level must be held for at least two system clock cycles, and data must be stable around each serial clock rise. Source-side minimums are 10 ns setup, 10 ns hold, 25 ns for each clock phase, 10 ns from the last clock rise to the load strobe, and a 20 ns load pulse. A load strobe driven high before system clock edge k shows up as wr_stb_o after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip enable; low clears all state (system clock domain) |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| sdata_i | input | 1 | Serial data pin, MSB first, asynchronous |
| sload_i | input | 1 | Load strobe pin, acts on rising edge, asynchronous |
| regs_o | output | 96 | Four 24-bit registers; register i occupies bits [24*i +: 24] |
| wr_stb_o | output | 1 | One-cycle pulse when a register is written |
| wr_idx_o | output | 2 | Index of the register written, valid with wr_stb_o |

## Verification
The bench uses the default parameters: a 24-bit word, a 2-bit index and two synchronizer stages. With these values all four registers can be addressed, and every one of the 24 bit positions can be checked against a behavioural reference model on every cycle. Because the synchronizer depth is two, the three-cycle latency from a load strobe to wr_stb_o can be checked exactly. The same depth lets the bench place serial clock toggles inside a held load strobe and clear chip-enable in the middle of a word.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int unsigned DEF_WORD_W      = 24;
  localparam int unsigned DEF_ADDR_W      = 2;
  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/cfg_loader_sync.sv
module cfg_loader_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(STAGES); s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_loader_edge.sv
module cfg_loader_edge #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= '0;
    else         last_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~last_q;
endmodule

// File: rtl/cfg_loader_shifter.sv
module cfg_loader_shifter #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (clr_i)   word_q <= '0;
    else if (shift_i) word_q <= {word_q[WORD_W-2:0], bit_i};
  end

  assign word_o = word_q;
endmodule

// File: rtl/cfg_loader_bank.sv
module cfg_loader_bank #(
  parameter int unsigned WORD_W   = 24,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned NUM_REGS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       wr_i,
  input  logic [ADDR_W-1:0]          idx_i,
  input  logic [WORD_W-1:0]          word_i,
  output logic [NUM_REGS*WORD_W-1:0] regs_o
);
  for (genvar g = 0; g < int'(NUM_REGS); g++) begin : g_ent
    logic [WORD_W-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             ent_q <= '0;
      else if (clr_i)                          ent_q <= '0;
      else if (wr_i && idx_i == ADDR_W'(g))    ent_q <= word_i;
    end
    assign regs_o[g*WORD_W +: WORD_W] = ent_q;
  end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
  parameter int unsigned WORD_W      = cfg_loader_pkg::DEF_WORD_W,
  parameter int unsigned ADDR_W      = cfg_loader_pkg::DEF_ADDR_W,
  parameter int unsigned SYNC_STAGES = cfg_loader_pkg::DEF_SYNC_STAGES,
  localparam int unsigned NUM_REGS   = 1 << ADDR_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ce_i,
  input  logic                       sclk_i,
  input  logic                       sdata_i,
  input  logic                       sload_i,
  output logic [NUM_REGS*WORD_W-1:0] regs_o,
  output logic                       wr_stb_o,
  output logic [ADDR_W-1:0]          wr_idx_o
);
  logic [2:0]        pin_s;     // {load, data, clk}
  logic [1:0]        rise_s;    // {load, clk}
  logic [WORD_W-1:0] word;
  logic              shift_en, load_go, clr;
  logic              stb_q;
  logic [ADDR_W-1:0] idx_q;

  cfg_loader_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sload_i, sdata_i, sclk_i}),
    .q_o   (pin_s)
  );

  cfg_loader_edge #(.W(2)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i ({pin_s[2], pin_s[0]}),
    .rise_o(rise_s)
  );

  assign clr      = ~ce_i;
  // clock rises during a held load are dropped so the word stays intact
  assign shift_en = ce_i & rise_s[0] & ~pin_s[2];
  assign load_go  = ce_i & rise_s[1];

  cfg_loader_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .shift_i(shift_en),
    .bit_i  (pin_s[1]),
    .word_o (word)
  );

  cfg_loader_bank #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .wr_i  (load_go),
    .idx_i (word[ADDR_W-1:0]),
    .word_i(word),
    .regs_o(regs_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= 1'b0;
      idx_q <= '0;
    end else begin
      stb_q <= load_go;
      if (load_go) idx_q <= word[ADDR_W-1:0];
    end
  end

  assign wr_stb_o = stb_q;
  assign wr_idx_o = idx_q;
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk #(
  parameter int unsigned WORD_W   = 24,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned NUM_REGS = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       ce_i,
  input logic [NUM_REGS*WORD_W-1:0] regs_o,
  input logic                       wr_stb_o,
  input logic [ADDR_W-1:0]          wr_idx_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o); // R6

  AST_CE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> (regs_o == '0 && !wr_stb_o)); // R9

  AST_IDX_TAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> (regs_o[int'(wr_idx_o)*WORD_W +: ADDR_W] == wr_idx_o)); // R4

  AST_QUIET_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(ce_i) && !wr_stb_o) |-> $stable(regs_o)); // R5

  for (genvar g = 0; g < int'(NUM_REGS); g++) begin : g_keep
    AST_OTHERS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && $past(ce_i) && wr_stb_o && wr_idx_o != ADDR_W'(g))
        |-> $stable(regs_o[g*WORD_W +: WORD_W])); // R5
  end
endmodule

bind cfg_serial_loader cfg_serial_loader_chk #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ce_i    (ce_i),
  .regs_o  (regs_o),
  .wr_stb_o(wr_stb_o),
  .wr_idx_o(wr_idx_o)
);

// File: tb/cfg_serial_loader_test.sv
module cfg_serial_loader_test;
  localparam int W    = 24;
  localparam int HOLD = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b1;
  logic        sclk = 1'b0, sdata = 1'b0, sload = 1'b0;
  logic [4*W-1:0] regs;
  logic        stb;
  logic [1:0]  idx;

  int checks = 0;
  int errs   = 0;
  int stb_cnt = 0;

  always #5 clk = ~clk;

  cfg_serial_loader uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce),
    .sclk_i(sclk), .sdata_i(sdata), .sload_i(sload),
    .regs_o(regs), .wr_stb_o(stb), .wr_idx_o(idx)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  function automatic logic [W-1:0] rg(input int i);
    return regs[i*W +: W];
  endfunction

  // behavioural reference model: pin history queue, newest first
  logic [2:0]   hist[$];
  logic [2:0]   h2, h3;
  logic [W-1:0] m_reg [4];
  logic [W-1:0] m_shift;
  logic         m_stb;
  logic [1:0]   m_idx;
  bit           cmp_on = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {3'b0, 3'b0, 3'b0, 3'b0};
      foreach (m_reg[i]) m_reg[i] = '0;
      m_shift = '0; m_stb = 1'b0; m_idx = '0;
    end else begin
      hist.push_front({sload, sdata, sclk});
      if (hist.size() > 6) void'(hist.pop_back());
      h2 = hist[2];
      h3 = hist[3];
      m_stb = 1'b0;
      if (!ce) begin
        foreach (m_reg[i]) m_reg[i] = '0;
        m_shift = '0;
      end else begin
        if (h2[2] && !h3[2]) begin
          m_reg[m_shift[1:0]] = m_shift;
          m_stb = 1'b1;
          m_idx = m_shift[1:0];
        end
        if (h2[0] && !h3[0] && !h2[2]) m_shift = {m_shift[W-2:0], h2[1]};
      end
    end
  end

  always @(negedge clk) begin
    if (stb) stb_cnt++;
    if (cmp_on) begin
      for (int i = 0; i < 4; i++) chk("R5 model regs", rg(i), m_reg[i]);
      chk("R7 model strobe", W'(stb), W'(m_stb));
      chk("R7 model index", W'(idx), W'(m_idx));
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // data is flipped while the clock is high to prove rise-only capture (R3)
  task automatic send_bits(input logic [W-1:0] w, input int nbits);
    for (int b = W - 1; b >= W - nbits; b--) begin
      sdata = w[b];  wait_n(HOLD);
      sclk  = 1'b1;  wait_n(HOLD);
      sdata = ~w[b]; wait_n(HOLD);
      sclk  = 1'b0;  wait_n(HOLD);
    end
  endtask

  task automatic pulse_load(input int len);
    wait_n(HOLD);
    sload = 1'b1; wait_n(len);
    sload = 1'b0; wait_n(HOLD + 2);
  endtask

  task automatic write_word(input logic [W-1:0] w);
    send_bits(w, W);
    pulse_load(HOLD);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R10 watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [W-1:0] exp_r [4];
    int c0;
    wait_n(3);
    for (int i = 0; i < 4; i++) chk("R1 reset regs", rg(i), '0);
    chk("R1 reset strobe", W'(stb), '0);
    chk("R1 reset index", W'(idx), '0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    wait_n(4);
    foreach (exp_r[i]) exp_r[i] = '0;

    // R2 R4: one word per register, distinct bit patterns
    exp_r[2] = 24'hA5C3_5E;  write_word(exp_r[2]);
    chk("R2 msb-first word in reg2", rg(2), exp_r[2]);
    chk("R5 reg0 untouched", rg(0), '0);
    exp_r[1] = 24'h80_0001;  write_word(exp_r[1]);
    chk("R4 reg1", rg(1), exp_r[1]);
    exp_r[3] = 24'hFFFF_FF;  write_word(exp_r[3]);
    chk("R4 reg3", rg(3), exp_r[3]);
    exp_r[0] = 24'h13_5790;  write_word(exp_r[0]);
    chk("R4 reg0", rg(0), exp_r[0]);
    chk("R3 data flips while clock high ignored", rg(2), exp_r[2]);

    // R5: overwrite one, others hold
    exp_r[1] = 24'h3C3C_3D;  write_word(exp_r[1]);
    chk("R5 reg1 rewritten", rg(1), exp_r[1]);
    chk("R5 reg0 held", rg(0), exp_r[0]);
    chk("R5 reg2 held", rg(2), exp_r[2]);
    chk("R5 reg3 held", rg(3), exp_r[3]);

    // R6: long load pulse yields one write
    send_bits(24'h0F0F_02, W);
    c0 = stb_cnt;
    pulse_load(30);
    exp_r[2] = 24'h0F0F_02;
    chk("R6 one write per long load", W'(stb_cnt - c0), W'(1));
    chk("R6 reg2 value", rg(2), exp_r[2]);

    // R8: serial clock toggles during held load do not shift
    send_bits(24'h55AA_01, W);
    wait_n(HOLD);
    sload = 1'b1; wait_n(HOLD);
    sdata = 1'b1;
    for (int t = 0; t < 5; t++) begin
      sclk = 1'b1; wait_n(HOLD);
      sclk = 1'b0; wait_n(HOLD);
    end
    sload = 1'b0; wait_n(HOLD + 2);
    c0 = stb_cnt;
    pulse_load(HOLD);
    exp_r[1] = 24'h55AA_01;
    chk("R8 word kept through clocks under load", rg(1), exp_r[1]);
    chk("R8 reload hit same register", W'(stb_cnt - c0), W'(1));
    chk("R8 reg2 untouched", rg(2), exp_r[2]);

    // R10 R7: strobe latency and index
    send_bits(24'h00_0003, W);
    wait_n(HOLD);
    sload = 1'b1;
    wait_n(1); chk("R10 no strobe after 1 edge", W'(stb), '0);
    wait_n(1); chk("R10 no strobe after 2 edges", W'(stb), '0);
    wait_n(1); chk("R10 strobe after 3 edges", W'(stb), W'(1));
    chk("R7 strobe index", W'(idx), W'(3));
    wait_n(1); chk("R7 strobe lasts one cycle", W'(stb), '0);
    sload = 1'b0; wait_n(HOLD + 2);
    exp_r[3] = 24'h00_0003;
    chk("R4 reg3 small word", rg(3), exp_r[3]);

    // R9: chip-enable clears state and blocks loads
    send_bits(24'hFEDC_BA, 10);
    ce = 1'b0; wait_n(2);
    for (int i = 0; i < 4; i++) chk("R9 cleared", rg(i), '0);
    c0 = stb_cnt;
    pulse_load(HOLD);
    chk("R9 no write while disabled", W'(stb_cnt - c0), '0);
    ce = 1'b1; wait_n(2);
    c0 = stb_cnt;
    pulse_load(HOLD);
    chk("R9 shift register cleared, write to reg0", W'(stb_cnt - c0), W'(1));
    chk("R9 reg0 zero", rg(0), '0);
    chk("R9 index zero", W'(idx), '0);

    wait_n(5);
    finish_run();
  end
endmodule